// File: doc/BRIEF.md
# Four-Channel Frame PWM Generator

This block drives four pulse-width-modulated outputs from one system clock. Each output has its own 32-bit control word on a small memory-mapped bus. The word holds three fields: an enable flag, an 8-bit high-time value and a 13-bit divider. The divider sets how many system clocks make one PWM tick. A frame is always 256 ticks long. Within a frame, the output is high for as many ticks as the high-time value says, starting at the first tick.

Software sets up a channel by writing its word. It reads the word back unchanged, so it can flip only the enable flag with a read-modify-write.

Each channel runs a two-state machine:
- **IDLE**: the tick divider and frame position are held at zero and the output is low.
- **RUN**: the divider and the frame position advance and the output compares the position with the high-time value.

The transitions are:
- *arm* (IDLE to RUN): the enable flag is seen set. The current high-time and divider are copied into the working copy.
- *halt* (RUN to IDLE): the enable flag is seen clear.
- *step* (RUN to RUN): the enable flag stays set. On the last tick of a frame, *step* also reloads the working copy from the control word.

Top module: `quad_pwm`

## Requirements
- R1: After reset every output is low and every control word reads as zero.
- R2: A read of a channel word returns the written value with the reserved bits (30:24 and 15:13) forced to zero. Read data appears on `bus_rdata` one clock after the read request and holds until the next read.
- R3: Channel n's word is at byte address 16·n for n = 0..3. A write to any other address changes no word and no output. A read from any other address returns zero.
- R4: While bit 31 of a channel's word is clear, its output is low. The output is low from the second clock edge after a write that clears bit 31. Writing all zeros disables the channel.
- R5: The high-time field is bits 23:16. The output is high while the frame position is strictly below it. A value of 0 gives a constant low output. A value of 255 gives 255 high ticks out of 256.
- R6: The divider field is bits 12:0. Each tick lasts (field + 1) clocks, so a field of 0 gives one tick per clock and a frame lasts 256·(field + 1) clocks.
- R7: A high-time or divider change written while the channel runs takes effect only at the start of the next frame.
- R8: The four channels run independently. A write to one channel does not disturb the others.
- R9: A channel enabled from the disabled state starts a fresh frame at position 0 on the second clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The bench targets the following corner cases:
- **High-time 0 and 255**: a comparison using less-than-or-equal instead of less-than would show up as one stray high tick, or as a constantly high output.
- **Mid-frame reconfiguration**: a design that skipped the frame-boundary reload would change the pulse inside the current frame. The per-clock comparison catches this on the first wrong cycle.
- **Disable, then re-enable**: this exposes a counter that is not cleared in IDLE, because the new frame would then start at a stale position.
- **Writes to unmapped and reserved addresses**: these catch a decoder that ignores the low address bits or the upper address bits.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
    localparam int WORD_W   = 32;
    localparam int EN_BIT   = 31;
    localparam int DUTY_LSB = 16;
    localparam int DIV_LSB  = 0;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/quad_pwm_regs.sv
module quad_pwm_regs
    import quad_pwm_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DUTY_W   = 8,
    parameter int DIV_W    = 13,
    parameter int ADDR_W   = 8,
    parameter int CH_SHIFT = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_valid,
    input  logic                             bus_write,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [WORD_W-1:0]                bus_wdata,
    output logic [WORD_W-1:0]                bus_rdata,
    output logic                             addr_hit,
    output logic [NUM_CH-1:0]                ch_en,
    output logic [NUM_CH-1:0][DUTY_W-1:0]    ch_duty,
    output logic [NUM_CH-1:0][DIV_W-1:0]     ch_div
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << CH_SHIFT) - 1);
    localparam logic [ADDR_W-1:0] NCH_A    = ADDR_W'(NUM_CH);

    logic [IDX_W-1:0]              sel_idx;
    logic [NUM_CH-1:0][WORD_W-1:0] words;
    logic [WORD_W-1:0]             rdata_q;

    // Decode: low address bits must be zero and the slot must exist
    always_comb begin
        sel_idx  = bus_addr[CH_SHIFT +: IDX_W];
        addr_hit = ((bus_addr & LOW_MASK) == '0) &&
                   ((bus_addr >> CH_SHIFT) < NCH_A);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_en[g]   <= 1'b0;
                ch_duty[g] <= '0;
                ch_div[g]  <= '0;
            end else if (bus_valid && bus_write && addr_hit &&
                         (sel_idx == IDX_W'(g))) begin
                ch_en[g]   <= bus_wdata[EN_BIT];
                ch_duty[g] <= bus_wdata[DUTY_LSB +: DUTY_W];
                ch_div[g]  <= bus_wdata[DIV_LSB +: DIV_W];
            end
        end

        always_comb begin
            words[g]                     = '0;
            words[g][EN_BIT]             = ch_en[g];
            words[g][DUTY_LSB +: DUTY_W] = ch_duty[g];
            words[g][DIV_LSB +: DIV_W]   = ch_div[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_valid && !bus_write) begin
            rdata_q <= addr_hit ? words[sel_idx] : '0;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/quad_pwm_channel.sv
module quad_pwm_channel
    import quad_pwm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int DIV_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [DUTY_W-1:0] cfg_duty,
    input  logic [DIV_W-1:0]  cfg_div,
    output logic              pwm,
    output logic [DUTY_W-1:0] pos_o,
    output logic [DUTY_W-1:0] act_duty_o
);
    localparam logic [DUTY_W-1:0] POS_LAST = '1;

    ch_state_e         state_q, state_d;
    logic [DIV_W-1:0]  presc_q;
    logic [DUTY_W-1:0] pos_q;
    logic [DUTY_W-1:0] act_duty_q;
    logic [DIV_W-1:0]  act_div_q;
    logic              tick_end;

    assign tick_end = (presc_q == act_div_q);

    // Next-state logic: arm, halt, step
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (cfg_en)  state_d = CH_RUN;
            CH_RUN:  if (!cfg_en) state_d = CH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Prescaler, frame position and working copy of the settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q    <= '0;
            pos_q      <= '0;
            act_duty_q <= '0;
            act_div_q  <= '0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    presc_q <= '0;
                    pos_q   <= '0;
                    if (cfg_en) begin
                        act_duty_q <= cfg_duty;
                        act_div_q  <= cfg_div;
                    end
                end
                CH_RUN: begin
                    if (!cfg_en) begin
                        presc_q <= '0;
                        pos_q   <= '0;
                    end else if (tick_end) begin
                        presc_q <= '0;
                        pos_q   <= pos_q + 1'b1;
                        if (pos_q == POS_LAST) begin
                            act_duty_q <= cfg_duty;
                            act_div_q  <= cfg_div;
                        end
                    end else begin
                        presc_q <= presc_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pwm        = (state_q == CH_RUN) && (pos_q < act_duty_q);
        pos_o      = pos_q;
        act_duty_o = act_duty_q;
    end
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
    import quad_pwm_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DUTY_W   = 8,
    parameter int DIV_W    = 13,
    parameter int ADDR_W   = 8,
    parameter int CH_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic                          addr_hit;
    logic [NUM_CH-1:0]             ch_en;
    logic [NUM_CH-1:0][DUTY_W-1:0] ch_duty;
    logic [NUM_CH-1:0][DIV_W-1:0]  ch_div;
    logic [NUM_CH-1:0][DUTY_W-1:0] ch_pos;
    logic [NUM_CH-1:0][DUTY_W-1:0] ch_act_duty;

    quad_pwm_regs #(
        .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .DIV_W(DIV_W),
        .ADDR_W(ADDR_W), .CH_SHIFT(CH_SHIFT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .addr_hit(addr_hit),
        .ch_en(ch_en), .ch_duty(ch_duty), .ch_div(ch_div)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        quad_pwm_channel #(.DUTY_W(DUTY_W), .DIV_W(DIV_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .cfg_en(ch_en[g]), .cfg_duty(ch_duty[g]), .cfg_div(ch_div[g]),
            .pwm(pwm_out[g]), .pos_o(ch_pos[g]), .act_duty_o(ch_act_duty[g])
        );
    end
endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk #(
    parameter int NUM_CH = 4,
    parameter int DUTY_W = 8,
    parameter int DIV_W  = 13
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_valid,
    input logic                          bus_write,
    input logic                          addr_hit,
    input logic [NUM_CH-1:0]             ch_en,
    input logic [NUM_CH-1:0][DUTY_W-1:0] ch_duty,
    input logic [NUM_CH-1:0][DIV_W-1:0]  ch_div,
    input logic [NUM_CH-1:0][DUTY_W-1:0] ch_pos,
    input logic [NUM_CH-1:0][DUTY_W-1:0] ch_act_duty,
    input logic [NUM_CH-1:0]             pwm_out
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_a
        a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(ch_en[g]) |-> !pwm_out[g]);

        a_r5_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_act_duty[g] == '0) |-> !pwm_out[g]);

        a_r6_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_pos[g] != $past(ch_pos[g])) |->
                ((ch_pos[g] == $past(ch_pos[g]) + 1'b1) || (ch_pos[g] == '0)));

        a_r7_reload_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ch_act_duty[g]) |-> (ch_pos[g] == '0));

        a_r3_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_write && !addr_hit) |=>
                ($stable(ch_en[g]) && $stable(ch_duty[g]) && $stable(ch_div[g])));
    end
endmodule

bind quad_pwm quad_pwm_chk #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .addr_hit(addr_hit), .ch_en(ch_en), .ch_duty(ch_duty), .ch_div(ch_div),
    .ch_pos(ch_pos), .ch_act_duty(ch_act_duty), .pwm_out(pwm_out)
);

// File: tb/sim_quad_pwm.sv
module sim_quad_pwm;
    localparam int CLK_P  = 10;
    localparam int NCH    = 4;
    localparam int WD_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    quad_pwm u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // Reference model: behavioural, integer based
    int m_en[NCH], m_du[NCH], m_dv[NCH];
    int m_run[NCH], m_pre[NCH], m_pos[NCH], m_ad[NCH], m_av[NCH];
    logic        cap_v;
    logic [7:0]  cap_a;
    logic [31:0] cap_d;

    always @(posedge clk) begin
        cap_v <= bus_valid && bus_write;
        cap_a <= bus_addr;
        cap_d <= bus_wdata;
    end

    function automatic bit mapped(logic [7:0] a);
        return (a % 16 == 0) && (a / 16 < NCH);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_en[c] = 0; m_du[c] = 0; m_dv[c] = 0;
                m_run[c] = 0; m_pre[c] = 0; m_pos[c] = 0; m_ad[c] = 0; m_av[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (m_run[c] == 0) begin
                    if (m_en[c] != 0) begin
                        m_run[c] = 1; m_pre[c] = 0; m_pos[c] = 0;
                        m_ad[c] = m_du[c]; m_av[c] = m_dv[c];
                    end
                end else if (m_en[c] == 0) begin
                    m_run[c] = 0; m_pre[c] = 0; m_pos[c] = 0;
                end else if (m_pre[c] >= m_av[c]) begin
                    m_pre[c] = 0;
                    m_pos[c] = m_pos[c] + 1;
                    if (m_pos[c] == 256) begin
                        m_pos[c] = 0; m_ad[c] = m_du[c]; m_av[c] = m_dv[c];
                    end
                end else begin
                    m_pre[c] = m_pre[c] + 1;
                end
            end
            if (cap_v === 1'b1 && mapped(cap_a)) begin
                m_en[cap_a/16] = int'(cap_d[31]);
                m_du[cap_a/16] = int'(cap_d[23:16]);
                m_dv[cap_a/16] = int'(cap_d[12:0]);
            end
            for (int c = 0; c < NCH; c++)
                chk({cur_req, " R8 per-clock output"}, 32'(pwm_out[c]),
                    32'((m_run[c] != 0) && (m_pos[c] < m_ad[c])));
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic count_high(input int ch, input int len, output int cnt);
        cnt = 0;
        repeat (len) begin
            @(negedge clk);
            if (pwm_out[ch]) cnt++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_P * WD_CYC);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int          hc;
        repeat (4) @(negedge clk);
        chk("R1 outputs at reset", 32'(pwm_out), 32'h0);
        rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            bus_rd(8'(c * 16), rv);
            chk("R1 word after reset", rv, 32'h0);
        end

        cur_req = "R2";
        bus_wr(8'h00, 32'hFF40_E002);
        bus_rd(8'h00, rv);
        chk("R2 reserved bits masked", rv, 32'h8040_0002);
        @(negedge clk);
        chk("R2 read data held", bus_rdata, 32'h8040_0002);

        cur_req = "R5";
        bus_wr(8'h10, 32'h8000_0000);
        bus_wr(8'h20, 32'h80FF_0001);
        bus_wr(8'h30, 32'h0080_0000);
        repeat (1200) @(negedge clk);
        count_high(0, 768, hc);
        chk("R6 duty 64 div 2 high clocks", 32'(hc), 32'd192);
        count_high(1, 256, hc);
        chk("R5 duty 0 constant low", 32'(hc), 32'd0);
        count_high(2, 512, hc);
        chk("R5 duty 255 high clocks", 32'(hc), 32'd510);
        count_high(3, 300, hc);
        chk("R4 disabled channel low", 32'(hc), 32'd0);

        cur_req = "R7";
        repeat (37) @(negedge clk);
        bus_wr(8'h00, 32'h80C0_0000);
        repeat (2000) @(negedge clk);
        count_high(0, 256, hc);
        chk("R7 new duty after frame", 32'(hc), 32'd192);

        cur_req = "R4";
        bus_rd(8'h20, rv);
        chk("R2 read before modify", rv, 32'h80FF_0001);
        bus_wr(8'h20, rv & 32'h7FFF_FFFF);
        @(negedge clk);
        chk("R4 low two edges after clear", 32'(pwm_out[2]), 32'h0);
        bus_rd(8'h20, rv);
        chk("R4 fields kept when disabled", rv, 32'h00FF_0001);
        count_high(2, 300, hc);
        chk("R4 stays low", 32'(hc), 32'd0);

        cur_req = "R9";
        bus_wr(8'h20, 32'h80FF_0001);
        chk("R9 not yet running after one edge", 32'(pwm_out[2]), 32'h0);
        @(negedge clk);
        chk("R9 frame starts high", 32'(pwm_out[2]), 32'h1);
        bus_wr(8'h10, 32'h0);
        bus_rd(8'h10, rv);
        chk("R4 all-zero write", rv, 32'h0);

        cur_req = "R3";
        bus_wr(8'h04, 32'h80FF_0000);
        bus_wr(8'h40, 32'h80FF_0000);
        bus_wr(8'h38, 32'h80FF_0000);
        bus_rd(8'h04, rv);
        chk("R3 unmapped read zero", rv, 32'h0);
        bus_rd(8'h30, rv);
        chk("R3 channel 3 untouched", rv, 32'h0080_0000);
        bus_rd(8'h00, rv);
        chk("R3 channel 0 untouched", rv, 32'h80C0_0000);
        count_high(3, 300, hc);
        chk("R3 output unaffected", 32'(hc), 32'd0);

        cur_req = "R8";
        bus_wr(8'h30, 32'h8080_0003);
        repeat (2500) @(negedge clk);
        count_high(3, 1024, hc);
        chk("R8 channel 3 independent", 32'(hc), 32'd512);
        count_high(0, 256, hc);
        chk("R8 channel 0 unchanged", 32'(hc), 32'd192);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule